// File: doc/BRIEF.md
# Descriptor Chain Walker

This block follows a linked list of transfer descriptors stored in a small word-addressed memory. It reaches that memory through a single read/write port with one cycle of read latency. A pulse on `go` loads the first descriptor pointer. For each descriptor, the walker reads four words and inspects the hardware-owned flag. If the flag is set, it hands the source address, destination address, length and address-stepping information to a data mover. It then waits for the mover's completion report, which carries the byte count actually moved, an error vector and a packet-end flag.

When the transfer completes, the walker writes the transferred count and a status byte back into the descriptor. It clears the ownership flag unless `keep_owned` is high, then follows the link pointer to the next descriptor. A descriptor that is not owned ends the chain. The exception is polling mode: there the walker waits a programmable number of clocks and reads the same descriptor again. An error report halts the walk when `stop_on_err` is set. The `stop` input sends the walker back to idle before a transfer starts, or while it waits to re-poll.

The walker reports through three outputs, for use by separate interrupt logic: a per-descriptor completion pulse with its status byte, a chain-end pulse and an error-halt pulse.

Top module: `sgc_walker`

## Requirements
- R1: After reset, `busy`, `mem_en`, `mv_req`, `desc_done`, `chain_done` and `err_halt` are all low.
- R2: A descriptor at word address A occupies words A to A+3, and the walker reads all four before acting on it. The four words are laid out as follows:
  - word A holds the source address.
  - word A+1 holds the destination address.
  - word A+2 holds the link pointer in bits [15:0] (its low AW bits address the next descriptor) and the transferred count in bits [31:16].
  - word A+3 holds the requested length in bits [15:0], the status byte in bits [23:16] and the control byte in bits [31:24].
- R3: For an owned descriptor (control bit 7 = 1), the walker raises `mv_req` with `mv_src`, `mv_dst`, `mv_len` and `mv_last`, where `mv_last` is control bit 0. It holds `mv_req` high until `mv_done` is seen.
- R4: `mv_rd_step` is 0 when control bit 1 (fixed read address) is set, and BEAT_BYTES otherwise. `mv_wr_step` follows control bit 2 in the same way.
- R5: After completion, the walker writes word A+2 with `mv_bytes` in bits [31:16], keeping the link bits [15:0]. It then writes word A+3 with the length unchanged and the status byte set to {`mv_eop`, 0, `mv_err[5:0]`}. In the status byte, bit 0 is the general error, bits 1 to 5 are length, CRC, truncation, PHY and collision, bit 6 is zero and bit 7 is packet end.
- R6: In the written-back control byte, bit 7 is cleared when `keep_owned` is 0 and left set when it is 1. All other control bits are unchanged.
- R7: `desc_done` is high for exactly one cycle per completed descriptor. It coincides with the write of word A+3, and `desc_status` carries that descriptor's status byte in that cycle.
- R8: With `poll_en` low, an unowned descriptor gives a one-cycle `chain_done` pulse and a return to idle. The walker starts no transfer for that descriptor and writes nothing to it.
- R9: With `poll_en` high, an unowned descriptor is read again. The first reads of two successive attempts start `poll_wait` + 7 cycles apart.
- R10: If a completion reports a nonzero error vector while `stop_on_err` is high, the walker pulses `err_halt` together with `desc_done`, goes idle and does not fetch the next descriptor. With `stop_on_err` low, it carries on along the chain.
- R11: `stop` high when ownership is checked, or during a poll wait, returns the walker to idle with no transfer, no write-back and no `chain_done`.
- R12: The next descriptor fetched is the one at the link pointer of the descriptor just completed, whatever its position in memory.
- R13: `go` has no effect while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| go | input | 1 | Start pulse; loads `start_ptr` when idle |
| stop | input | 1 | Abandon the walk at the ownership check or during a poll wait |
| poll_en | input | 1 | Re-poll unowned descriptors instead of ending the chain |
| stop_on_err | input | 1 | Halt on a reported transfer error |
| keep_owned | input | 1 | 1 leaves the ownership bit set on write-back |
| poll_wait | input | WAITW | Clocks to wait before a re-poll |
| start_ptr | input | AW | Word address of the first descriptor |
| mem_en | output | 1 | Descriptor memory access strobe |
| mem_we | output | 1 | Write qualifier for `mem_en` |
| mem_addr | output | AW | Descriptor memory word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one cycle after a read |
| mv_req | output | 1 | Transfer request to the data mover |
| mv_src | output | 32 | Source address |
| mv_dst | output | 32 | Destination address |
| mv_len | output | 16 | Requested byte length |
| mv_rd_step | output | STEPW | Source address increment per beat |
| mv_wr_step | output | STEPW | Destination address increment per beat |
| mv_last | output | 1 | Packet-end flag from the control byte |
| mv_done | input | 1 | Mover completion pulse |
| mv_bytes | input | 16 | Bytes actually moved |
| mv_err | input | 6 | Error vector (general, length, CRC, truncation, PHY, collision) |
| mv_eop | input | 1 | Packet end seen by the mover |
| busy | output | 1 | Walker not idle |
| desc_done | output | 1 | One-cycle descriptor completion pulse |
| desc_status | output | 8 | Status byte of the completed descriptor |
| chain_done | output | 1 | One-cycle chain-end pulse |
| err_halt | output | 1 | One-cycle pulse when the walk halts on an error |

## Verification
The bench builds the walker with AW = 8, WAITW = 8 and BEAT_BYTES = 4. With these values the whole 256-word descriptor memory can be modelled directly in the bench, and the poll wait can be swept across its full range, including both ends (0 and 255). Chains of one to four descriptors are placed at scattered addresses and run with both ownership settings. An injected error is moved across every chain position, with halting on and off. The fixed-address bits and the packet-end bits vary from descriptor to descriptor, so each write-back word and each stepping value can be predicted arithmetically from the descriptor contents.

// File: rtl/sgc_pkg.sv
package sgc_pkg;
  localparam int WORDS_PER_DESC = 4;
  localparam int CTL_LAST  = 0;
  localparam int CTL_FIXRD = 1;
  localparam int CTL_FIXWR = 2;
  localparam int CTL_OWN   = 7;
  localparam int ERRW      = 6;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_CHECK, S_MOVE, S_WB_CNT, S_WB_CTL, S_WAIT
  } walk_st_t;
endpackage

// File: rtl/sgc_poll_timer.sv
module sgc_poll_timer #(
  parameter int WAITW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WAITW-1:0] wait_val,
  input  logic             run,
  output logic             expired
);
  logic [WAITW-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load | (run & (cnt_q != '0));
    cnt_d  = load ? wait_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = run & (cnt_q == '0);

  assert_expire_only_running_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (load && wait_val != '0) |=> !expired);
endmodule

// File: rtl/sgc_desc_hold.sv
module sgc_desc_hold
  import sgc_pkg::*;
#(
  parameter int AW         = 8,
  parameter int BEAT_BYTES = 4,
  parameter int STEPW      = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic [1:0]       cap_idx,
  input  logic [31:0]      rdata,
  input  logic             res_en,
  input  logic [15:0]      mv_bytes,
  input  logic [ERRW-1:0]  mv_err,
  input  logic             mv_eop,
  input  logic             keep_owned,
  output logic [31:0]      src,
  output logic [31:0]      dst,
  output logic [15:0]      len,
  output logic [AW-1:0]    next_ptr,
  output logic             owned,
  output logic             last,
  output logic [STEPW-1:0] rd_step,
  output logic [STEPW-1:0] wr_step,
  output logic [7:0]       status,
  output logic             err_any,
  output logic [31:0]      wb_link,
  output logic [31:0]      wb_info
);
  logic [31:0] addr_q [2];
  logic [15:0] link_q, len_q, bytes_q;
  logic [7:0]  ctl_q, ctl_wb, st_q, st_d;

  // address words (source, destination) share one capture structure
  for (genvar w = 0; w < 2; w++) begin : g_addr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) addr_q[w] <= '0;
      else if (cap_en && cap_idx == 2'(w)) addr_q[w] <= rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) link_q <= '0;
    else if (cap_en && cap_idx == 2'd2) link_q <= rdata[15:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
      ctl_q <= '0;
    end else if (cap_en && cap_idx == 2'd3) begin
      len_q <= rdata[15:0];
      ctl_q <= rdata[31:24];
    end
  end

  always_comb st_d = {mv_eop, 1'b0, mv_err};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bytes_q <= '0;
      st_q    <= '0;
    end else if (res_en) begin
      bytes_q <= mv_bytes;
      st_q    <= st_d;
    end
  end

  always_comb begin
    ctl_wb          = ctl_q;
    ctl_wb[CTL_OWN] = ctl_q[CTL_OWN] & keep_owned;
  end

  assign src      = addr_q[0];
  assign dst      = addr_q[1];
  assign len      = len_q;
  assign next_ptr = link_q[AW-1:0];
  assign owned    = ctl_q[CTL_OWN];
  assign last     = ctl_q[CTL_LAST];
  assign rd_step  = ctl_q[CTL_FIXRD] ? '0 : STEPW'(BEAT_BYTES);
  assign wr_step  = ctl_q[CTL_FIXWR] ? '0 : STEPW'(BEAT_BYTES);
  assign status   = st_q;
  assign err_any  = |st_q[ERRW-1:0];
  assign wb_link  = {bytes_q, link_q};
  assign wb_info  = {ctl_wb, st_q, len_q};

  assert_err_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_en |=> (err_any == ($past(mv_err) != '0)));
endmodule

// File: rtl/sgc_fsm.sv
module sgc_fsm
  import sgc_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          stop,
  input  logic          poll_en,
  input  logic          stop_on_err,
  input  logic [AW-1:0] start_ptr,
  input  logic          owned,
  input  logic [AW-1:0] next_ptr,
  input  logic          err_any,
  input  logic          tmr_expired,
  input  logic          mv_done,
  output logic          busy,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic          wb_sel,
  output logic          cap_en,
  output logic [1:0]    cap_idx,
  output logic          res_en,
  output logic          mv_req,
  output logic          tmr_load,
  output logic          tmr_run,
  output logic          desc_done,
  output logic          chain_done,
  output logic          err_halt
);
  walk_st_t      st_q, st_d;
  logic [AW-1:0] base_q, base_d;
  logic [2:0]    fcnt_q, fcnt_d;
  logic [1:0]    off;

  always_comb begin
    st_d = st_q; base_d = base_q; fcnt_d = fcnt_q;
    mem_en = 1'b0; mem_we = 1'b0; off = 2'd0; wb_sel = 1'b0;
    cap_en = 1'b0; res_en = 1'b0; mv_req = 1'b0;
    tmr_load = 1'b0; tmr_run = 1'b0;
    desc_done = 1'b0; chain_done = 1'b0; err_halt = 1'b0;
    unique case (st_q)
      S_IDLE: if (go) begin
        base_d = start_ptr; fcnt_d = '0; st_d = S_FETCH;
      end
      S_FETCH: begin
        mem_en = ~fcnt_q[2];
        off    = fcnt_q[1:0];
        cap_en = (fcnt_q != 3'd0);
        if (fcnt_q[2]) st_d = S_CHECK;
        else fcnt_d = fcnt_q + 3'd1;
      end
      S_CHECK: begin
        if (stop) st_d = S_IDLE;
        else if (owned) st_d = S_MOVE;
        else if (poll_en) begin tmr_load = 1'b1; st_d = S_WAIT; end
        else begin chain_done = 1'b1; st_d = S_IDLE; end
      end
      S_MOVE: begin
        mv_req = 1'b1;
        if (mv_done) begin res_en = 1'b1; st_d = S_WB_CNT; end
      end
      S_WB_CNT: begin
        mem_en = 1'b1; mem_we = 1'b1; off = 2'd2; st_d = S_WB_CTL;
      end
      S_WB_CTL: begin
        mem_en = 1'b1; mem_we = 1'b1; off = 2'd3; wb_sel = 1'b1;
        desc_done = 1'b1;
        if (err_any && stop_on_err) begin
          err_halt = 1'b1; st_d = S_IDLE;
        end else begin
          base_d = next_ptr; fcnt_d = '0; st_d = S_FETCH;
        end
      end
      S_WAIT: begin
        tmr_run = 1'b1;
        if (stop) st_d = S_IDLE;
        else if (tmr_expired) begin fcnt_d = '0; st_d = S_FETCH; end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      base_q <= '0;
      fcnt_q <= '0;
    end else begin
      st_q   <= st_d;
      base_q <= base_d;
      fcnt_q <= fcnt_d;
    end
  end

  assign cap_idx  = fcnt_q[1:0] - 2'd1;
  assign mem_addr = base_q + {{(AW-2){1'b0}}, off};
  assign busy     = (st_q != S_IDLE);

  assert_req_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_req && !mv_done) |=> mv_req);
  assert_chain_end_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    chain_done |=> !busy);
  assert_halt_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_halt |=> !busy);
  assert_pulse_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(desc_done && chain_done));
  assert_halt_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_halt |-> desc_done);
endmodule

// File: rtl/sgc_walker.sv
module sgc_walker
  import sgc_pkg::*;
#(
  parameter int AW         = 8,
  parameter int WAITW      = 8,
  parameter int BEAT_BYTES = 4,
  localparam int STEPW     = $clog2(BEAT_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             stop,
  input  logic             poll_en,
  input  logic             stop_on_err,
  input  logic             keep_owned,
  input  logic [WAITW-1:0] poll_wait,
  input  logic [AW-1:0]    start_ptr,
  output logic             mem_en,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata,
  output logic             mv_req,
  output logic [31:0]      mv_src,
  output logic [31:0]      mv_dst,
  output logic [15:0]      mv_len,
  output logic [STEPW-1:0] mv_rd_step,
  output logic [STEPW-1:0] mv_wr_step,
  output logic             mv_last,
  input  logic             mv_done,
  input  logic [15:0]      mv_bytes,
  input  logic [ERRW-1:0]  mv_err,
  input  logic             mv_eop,
  output logic             busy,
  output logic             desc_done,
  output logic [7:0]       desc_status,
  output logic             chain_done,
  output logic             err_halt
);
  logic [1:0]    rs_q;
  logic          rst_ni;
  logic          owned, err_any, tmr_expired, tmr_load, tmr_run;
  logic          cap_en, res_en, wb_sel;
  logic [1:0]    cap_idx;
  logic [AW-1:0] next_ptr;
  logic [31:0]   wb_link, wb_info;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  sgc_fsm #(.AW(AW)) fsm_i (
    .clk(clk), .rst_n(rst_ni), .go(go), .stop(stop), .poll_en(poll_en),
    .stop_on_err(stop_on_err), .start_ptr(start_ptr), .owned(owned),
    .next_ptr(next_ptr), .err_any(err_any), .tmr_expired(tmr_expired),
    .mv_done(mv_done), .busy(busy), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .wb_sel(wb_sel), .cap_en(cap_en), .cap_idx(cap_idx),
    .res_en(res_en), .mv_req(mv_req), .tmr_load(tmr_load), .tmr_run(tmr_run),
    .desc_done(desc_done), .chain_done(chain_done), .err_halt(err_halt)
  );

  sgc_desc_hold #(.AW(AW), .BEAT_BYTES(BEAT_BYTES), .STEPW(STEPW)) hold_i (
    .clk(clk), .rst_n(rst_ni), .cap_en(cap_en), .cap_idx(cap_idx),
    .rdata(mem_rdata), .res_en(res_en), .mv_bytes(mv_bytes), .mv_err(mv_err),
    .mv_eop(mv_eop), .keep_owned(keep_owned), .src(mv_src), .dst(mv_dst),
    .len(mv_len), .next_ptr(next_ptr), .owned(owned), .last(mv_last),
    .rd_step(mv_rd_step), .wr_step(mv_wr_step), .status(desc_status),
    .err_any(err_any), .wb_link(wb_link), .wb_info(wb_info)
  );

  sgc_poll_timer #(.WAITW(WAITW)) tmr_i (
    .clk(clk), .rst_n(rst_ni), .load(tmr_load), .wait_val(poll_wait),
    .run(tmr_run), .expired(tmr_expired)
  );

  assign mem_wdata = wb_sel ? wb_info : wb_link;

  assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_ni)
    !busy |-> (!mem_en && !mv_req));
  assert_done_on_write_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    desc_done |-> (mem_en && mem_we));
  assert_owner_cleared_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (desc_done && !keep_owned) |-> !mem_wdata[31]);
  assert_status_written_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    desc_done |-> (mem_wdata[23:16] == desc_status));
endmodule

// File: tb/sgc_walker_tb.sv
module sgc_walker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int WAITW = 8;
  localparam int BEAT = 4;
  localparam int STEPW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic go = 0, stop = 0, poll_en = 0, stop_on_err = 0, keep_owned = 0;
  logic [WAITW-1:0] poll_wait = '0;
  logic [AW-1:0] start_ptr = '0;
  logic mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;
  logic mv_req, mv_last;
  logic [31:0] mv_src, mv_dst;
  logic [15:0] mv_len;
  logic [STEPW-1:0] mv_rd_step, mv_wr_step;
  logic mv_done;
  logic [15:0] mv_bytes;
  logic [5:0] mv_err;
  logic mv_eop;
  logic busy, desc_done, chain_done, err_halt;
  logic [7:0] desc_status;

  always #(CLK_PERIOD/2) clk = ~clk;

  sgc_walker #(.AW(AW), .WAITW(WAITW), .BEAT_BYTES(BEAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .go(go), .stop(stop), .poll_en(poll_en),
    .stop_on_err(stop_on_err), .keep_owned(keep_owned), .poll_wait(poll_wait),
    .start_ptr(start_ptr), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mv_req(mv_req), .mv_src(mv_src),
    .mv_dst(mv_dst), .mv_len(mv_len), .mv_rd_step(mv_rd_step), .mv_wr_step(mv_wr_step),
    .mv_last(mv_last), .mv_done(mv_done), .mv_bytes(mv_bytes), .mv_err(mv_err),
    .mv_eop(mv_eop), .busy(busy), .desc_done(desc_done), .desc_status(desc_status),
    .chain_done(chain_done), .err_halt(err_halt)
  );

  int n_tot = 0, n_bad = 0;
  bit finished = 0;
  int cyc = 0;
  int n_dd = 0, n_cd = 0, n_eh = 0, n_mv = 0;
  int rdt [0:7];
  int nrd = 0;
  logic [AW-1:0] log_addr = '0;
  logic [7:0] exp_st = '0;
  logic req_prev = 0;
  int mcnt = 0;
  logic [31:0] mem [0:255];
  logic [31:0] sv [0:7];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tot++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model: one-cycle read latency
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_en) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else mem_rdata <= mem[mem_addr];
    end
  end

  // mover stub: latency src[5:4]+1, truncation src[3:0], error src[13:8], eop src[16]
  always @(posedge clk) begin
    if (!rst_n) begin
      mv_done <= 0; mcnt <= 0; mv_bytes <= '0; mv_err <= '0; mv_eop <= 0;
    end else if (mv_done) mv_done <= 0;
    else if (mv_req) begin
      if (mcnt == int'(mv_src[5:4])) begin
        mv_done <= 1; mcnt <= 0;
        mv_bytes <= mv_len - 16'(mv_src[3:0]);
        mv_err <= mv_src[13:8];
        mv_eop <= mv_src[16];
        exp_st <= {mv_src[16], 1'b0, mv_src[13:8]};
      end else mcnt <= mcnt + 1;
    end
  end

  // monitors, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (desc_done) begin
        n_dd++;
        chk(desc_status == exp_st, "R7 status", desc_status, exp_st);
      end
      if (chain_done) n_cd++;
      if (err_halt) n_eh++;
      if (mv_req && !req_prev) begin
        n_mv++;
        chk(mv_rd_step == (mv_src[20] ? 3'd0 : 3'(BEAT)), "R4 rd step", mv_rd_step, mv_src[20] ? 0 : BEAT);
        chk(mv_wr_step == (mv_src[21] ? 3'd0 : 3'(BEAT)), "R4 wr step", mv_wr_step, mv_src[21] ? 0 : BEAT);
        chk(mv_last == mv_src[22], "R3 last", mv_last, mv_src[22]);
        chk(mv_dst == 32'h8000_0000 + {mv_src[31:24], 6'd0}, "R3 dst", mv_dst, 32'h8000_0000 + {mv_src[31:24], 6'd0});
      end
      req_prev = mv_req;
      if (mem_en && !mem_we && mem_addr == log_addr && nrd < 8) begin
        rdt[nrd] = cyc; nrd++;
      end
    end
  end

  function automatic int da(input int i);
    return 16 + ((i * 5 + 3) % 8) * 8;
  endfunction

  function automatic logic [31:0] mk_src(input int i, input int run, input logic [5:0] err);
    logic [31:0] s;
    s = '0;
    s[3:0]   = 4'((i * 3 + run) % 8);
    s[5:4]   = 2'((i + run) % 4);
    s[13:8]  = err;
    s[16]    = 1'((i + run) % 2);
    s[20]    = 1'(i % 2);
    s[21]    = ((i + run) % 3) == 0;
    s[22]    = 1'((run + i + 1) % 2);
    s[31:24] = 8'(i);
    return s;
  endfunction

  function automatic logic [15:0] len_of(input logic [31:0] s);
    return 16'(32 + int'(s[31:24]) * 3 + int'(s[3:0]));
  endfunction

  function automatic logic [7:0] ctl_of(input logic [31:0] s, input bit own);
    return {own, 4'b0000, s[21], s[20], s[22]};
  endfunction

  task automatic put_desc(input int i, input int run, input bit own, input logic [5:0] err);
    logic [31:0] s;
    int a;
    s = mk_src(i, run, err);
    a = da(i);
    sv[i] = s;
    mem[a]     = s;
    mem[a + 1] = 32'h8000_0000 + {18'd0, s[31:24], 6'd0};
    mem[a + 2] = {16'hABCD, 16'(da(i + 1))};
    mem[a + 3] = {ctl_of(s, own), 8'h5A, len_of(s)};
  endtask

  task automatic clr_mem();
    for (int k = 0; k < 256; k++) mem[k] = '0;
    n_dd = 0; n_cd = 0; n_eh = 0; n_mv = 0;
  endtask

  task automatic run_wait(input logic [AW-1:0] p);
    int t;
    start_ptr = p;
    @(negedge clk) go = 1;
    @(negedge clk) go = 0;
    t = 0;
    while (busy && t < 3000) begin @(negedge clk); t++; end
    chk(!busy, "R8 walker returned idle", busy, 0);
  endtask

  // processed descriptor i written back as R5/R6 require
  task automatic chk_done(input int i, input bit keep);
    logic [31:0] s, e2, e3;
    int a;
    s = sv[i]; a = da(i);
    e2 = {len_of(s) - 16'(s[3:0]), 16'(da(i + 1))};
    e3 = {ctl_of(s, keep), {s[16], 1'b0, s[13:8]}, len_of(s)};
    chk(mem[a + 2] == e2, "R5 R12 count/link word", mem[a + 2], e2);
    chk(mem[a + 3] == e3, "R5 R6 info word", mem[a + 3], e3);
  endtask

  task automatic chk_untouched(input int i, input string req);
    int a;
    a = da(i);
    chk(mem[a + 2][31:16] == 16'hABCD, req, mem[a + 2], {16'hABCD, 16'(da(i + 1))});
    chk(mem[a + 3][23:16] == 8'h5A, req, mem[a + 3][23:16], 8'h5A);
  endtask

  initial begin
    for (int k = 0; k < 256; k++) mem[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(!busy && !mem_en && !mv_req, "R1 idle outputs", {busy, mem_en, mv_req}, 0);
    chk(!desc_done && !chain_done && !err_halt, "R1 pulses low", {desc_done, chain_done, err_halt}, 0);

    // R2 R3 R5 R6 R8 R12: chain length and ownership sweep
    for (int k = 0; k < 2; k++) begin
      for (int n = 1; n <= 4; n++) begin
        clr_mem();
        for (int i = 0; i < n; i++) put_desc(i, n + 4 * k, 1'b1, 6'd0);
        put_desc(n, n + 4 * k, 1'b0, 6'd0);
        keep_owned = 1'(k); poll_en = 0; stop_on_err = 0;
        run_wait(AW'(da(0)));
        for (int i = 0; i < n; i++) chk_done(i, 1'(k));
        chk_untouched(n, "R8 unowned untouched");
        chk(n_dd == n, "R7 done count", n_dd, n);
        chk(n_cd == 1, "R8 chain_done once", n_cd, 1);
        chk(n_mv == n, "R8 no transfer for unowned", n_mv, n);
        chk(n_eh == 0, "R10 no halt", n_eh, 0);
      end
    end

    // R10: error at each position, halting on and off
    for (int soe = 0; soe < 2; soe++) begin
      for (int j = 0; j < 4; j++) begin
        clr_mem();
        for (int i = 0; i < 4; i++)
          put_desc(i, 9 + j, 1'b1, (i == j) ? (6'h01 | 6'(1 << (j + 1))) : 6'd0);
        put_desc(4, 9 + j, 1'b0, 6'd0);
        keep_owned = 0; poll_en = 0; stop_on_err = 1'(soe);
        run_wait(AW'(da(0)));
        if (soe == 1) begin
          for (int i = 0; i <= j; i++) chk_done(i, 1'b0);
          chk_untouched(j + 1, "R10 next not processed");
          chk(n_eh == 1, "R10 halt pulse", n_eh, 1);
          chk(n_cd == 0, "R10 no chain_done", n_cd, 0);
          chk(n_dd == j + 1, "R10 done count", n_dd, j + 1);
        end else begin
          for (int i = 0; i < 4; i++) chk_done(i, 1'b0);
          chk(n_eh == 0, "R10 continue", n_eh, 0);
          chk(n_cd == 1, "R10 chain end", n_cd, 1);
        end
      end
    end

    // R11: stop at ownership check
    clr_mem();
    put_desc(0, 3, 1'b1, 6'd0);
    put_desc(1, 3, 1'b0, 6'd0);
    stop = 1; stop_on_err = 0; poll_en = 0;
    run_wait(AW'(da(0)));
    stop = 0;
    chk(n_mv == 0, "R11 no transfer", n_mv, 0);
    chk(n_cd == 0 && n_dd == 0, "R11 no pulses", n_cd + n_dd, 0);
    chk_untouched(0, "R11 no writeback");

    // R9 R11 R13: polling with several waits
    for (int w = 0; w < 4; w++) begin
      int wv, t;
      wv = (w == 0) ? 0 : (w == 1) ? 3 : (w == 2) ? 17 : 255;
      clr_mem();
      put_desc(0, w, 1'b1, 6'd0);
      put_desc(1, w, 1'b0, 6'd0);
      put_desc(2, w, 1'b0, 6'd0);
      mem[200] = 32'h1; mem[201] = 32'h2; mem[202] = 32'hABCD_00C8;
      mem[203] = {8'h80, 8'h5A, 16'd40};
      poll_en = 1; poll_wait = 8'(wv); keep_owned = 0;
      log_addr = AW'(da(1)); nrd = 0;
      start_ptr = AW'(da(0));
      @(negedge clk) go = 1;
      @(negedge clk) go = 0;
      t = 0;
      while (nrd < 3 && t < 5000) begin @(negedge clk); t++; end
      chk(rdt[1] - rdt[0] == wv + 7, "R9 poll interval", rdt[1] - rdt[0], wv + 7);
      chk(rdt[2] - rdt[1] == wv + 7, "R9 poll interval again", rdt[2] - rdt[1], wv + 7);
      start_ptr = 8'd200;
      @(negedge clk) go = 1;
      @(negedge clk) go = 0;
      mem[da(1) + 3][31] = 1'b1;
      log_addr = AW'(da(2)); nrd = 0;
      t = 0;
      while (nrd < 2 && t < 5000) begin @(negedge clk); t++; end
      stop = 1;
      t = 0;
      while (busy && t < 600) begin @(negedge clk); t++; end
      stop = 0;
      chk(!busy, "R11 stop during wait", busy, 0);
      chk(n_dd == 2, "R9 polled descriptor completed", n_dd, 2);
      chk(n_cd == 0, "R11 no chain_done", n_cd, 0);
      chk(n_mv == 2, "R13 go ignored", n_mv, 2);
      chk(mem[203][23:16] == 8'h5A, "R13 other chain untouched", mem[203][23:16], 8'h5A);
      chk_done(1, 1'b0);
      poll_en = 0;
    end

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_tot, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tot++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", n_tot, n_bad);
      $finish;
    end
  end
endmodule